// File: doc/BRIEF.md
# Third-Order Noise-Shaped Fractional Divide Controller

This block produces the division ratio for a fractional-N feedback divider, one value per divider cycle. Software-facing logic presents an integer part, a fractional numerator and a modulus. Three cascaded first-order accumulators make up the noise shaper. Each accumulator wraps modulo the programmed modulus. Their carries are combined into a correction term between -3 and +4. The block outputs the integer part plus that correction, and the long-run mean of the output equals integer + fraction / modulus. The block also decodes a two-bit reference prescale selection into a one-hot control word. That word leaves the block as a control output only.

A small control state machine governs when new settings apply. It has three states. `ST_IDLE` is the state after reset: nothing has been programmed and divider ticks are ignored. `ST_ARMED` means new settings have been captured into a shadow set and are waiting. `ST_RUN` means the modulator steps once per tick. There are two transitions. `T_LOAD` goes from any state to `ST_ARMED` when `cfg_load` is high. `T_COMMIT` goes from `ST_ARMED` to `ST_RUN` on a divider tick. At commit the shadow set becomes active, all accumulators and carry delays clear, and the output becomes the integer part. In the same clock, `T_LOAD` takes priority for the next state while the tick is still handled in the current state.

Top module: `sdm_divctl`

## Requirements
- R1: After reset, `div_ratio` is 21 and `ref_ctl` is 4'b0010. Before the first `cfg_load`, divider ticks leave both unchanged.
- R2: Asserting `cfg_load` alone does not change `div_ratio`. On the first `div_tick` after a load, the new settings apply, and in the next cycle `div_ratio` equals the clamped integer part.
- R3: The integer part is clamped into 21..123. A value below 21 becomes 21, and a value above 123 becomes 123.
- R4: A modulus of 0 is treated as 1. A fraction greater than or equal to the modulus is replaced by modulus - 1.
- R5: With a fraction of 0, every `div_ratio` value equals the integer part.
- R6: Take M as the effective modulus, I as the integer part and F as the fraction. Skip the first three outputs after a commit. Over any 6*M consecutive outputs after that, the sum of `div_ratio` is exactly 6*M*I + 6*F.
- R7: While running, `div_ratio` minus the integer part always lies in -3..+4.
- R8: `div_ratio` changes only in the cycle after a `div_tick`.
- R9: `cfg_ref` is decoded into one-hot `ref_ctl`. Code 0 sets bit 0 (double), code 1 sets bit 1 (pass-through), code 2 sets bit 2 (divide by 2) and code 3 sets bit 3 (divide by 4). The code is committed together with the other settings.
- R10: A reload while running keeps the old settings in use until the next tick. The commit then restarts the sequence from cleared accumulators, so the outputs repeat those of a fresh commit with the same settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_tick | input | 1 | One-cycle strobe marking a divider-cycle boundary |
| cfg_load | input | 1 | Captures the cfg_* inputs into the shadow set |
| cfg_int | input | 7 | Integer part of the ratio |
| cfg_frac | input | 11 | Fractional numerator |
| cfg_mod | input | 11 | Modulus |
| cfg_ref | input | 2 | Reference prescale selection code |
| div_ratio | output | 8 | Instantaneous divide value |
| ref_ctl | output | 4 | One-hot reference prescale control |

## Verification
The mean check runs over seven settings. A small odd modulus and a modulus of 2 show the correction sequence averaging correctly over short periods. A modulus of 2047 with fraction 2046, and a fraction of 250 over 1000, cover wide accumulators and many carries. Out-of-range integer, fraction and modulus values separate the clamps from the arithmetic, because only the clamped values give the exact sum. A zero-fraction setting isolates the constant-output path. A mid-run reload with a sequence replay shows that the accumulators and carry delays are cleared at commit rather than carried over.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        REF_X2 = 2'd0,
        REF_X1 = 2'd1,
        REF_D2 = 2'd2,
        REF_D4 = 2'd3
    } ref_code_t;

    localparam int NUM_REF = 4;

endpackage

// File: rtl/sdm_cfg_ctrl.sv
module sdm_cfg_ctrl
    import sdm_pkg::*;
#(
    parameter int INT_W   = 7,
    parameter int MOD_W   = 11,
    parameter int INT_MIN = 21,
    parameter int INT_MAX = 123
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             div_tick,
    input  logic [INT_W-1:0] cfg_int,
    input  logic [MOD_W-1:0] cfg_frac,
    input  logic [MOD_W-1:0] cfg_mod,
    input  logic [1:0]       cfg_ref,
    output logic             commit,
    output logic             step,
    output logic [INT_W-1:0] sh_int,
    output logic [INT_W-1:0] act_int,
    output logic [MOD_W-1:0] act_frac,
    output logic [MOD_W-1:0] act_mod,
    output logic [1:0]       act_ref
);

    localparam logic [INT_W-1:0] LO_I = INT_W'(INT_MIN);
    localparam logic [INT_W-1:0] HI_I = INT_W'(INT_MAX);
    localparam logic [MOD_W-1:0] ONE_M = MOD_W'(1);

    ctl_state_t state_q, state_d;

    logic [INT_W-1:0] int_c;
    logic [MOD_W-1:0] mod_c, frac_c;
    logic [MOD_W-1:0] sh_frac, sh_mod;
    logic [1:0]       sh_ref;

    // Clamping of the incoming settings
    always_comb begin
        mod_c  = (cfg_mod == '0) ? ONE_M : cfg_mod;
        frac_c = (cfg_frac >= mod_c) ? (mod_c - ONE_M) : cfg_frac;
        if (cfg_int < LO_I)      int_c = LO_I;
        else if (cfg_int > HI_I) int_c = HI_I;
        else                     int_c = cfg_int;
    end

    // Next state: T_COMMIT (ARMED -> RUN), T_LOAD (any -> ARMED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_IDLE;
            ST_ARMED: state_d = div_tick ? ST_RUN : ST_ARMED;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
        if (cfg_load) state_d = ST_ARMED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // State outputs
    always_comb begin
        commit = 1'b0;
        step   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: commit = div_tick;
            ST_RUN:   step   = div_tick;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_int   <= LO_I;
            sh_frac  <= '0;
            sh_mod   <= ONE_M;
            sh_ref   <= REF_X1;
            act_int  <= LO_I;
            act_frac <= '0;
            act_mod  <= ONE_M;
            act_ref  <= REF_X1;
        end else begin
            if (cfg_load) begin
                sh_int  <= int_c;
                sh_frac <= frac_c;
                sh_mod  <= mod_c;
                sh_ref  <= cfg_ref;
            end
            if (commit) begin
                act_int  <= sh_int;
                act_frac <= sh_frac;
                act_mod  <= sh_mod;
                act_ref  <= sh_ref;
            end
        end
    end

    p_int_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_int >= LO_I && act_int <= HI_I));

    p_frac_below_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_frac < act_mod && act_mod != '0));

    p_commit_only_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARMED) |=> $stable(act_int) && $stable(act_mod));

endmodule

// File: rtl/sdm_acc_stage.sv
module sdm_acc_stage #(
    parameter int MOD_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [MOD_W-1:0] add_in,
    input  logic [MOD_W-1:0] modv,
    output logic [MOD_W-1:0] acc_nxt,
    output logic             carry
);

    logic [MOD_W-1:0] acc_q;
    logic [MOD_W:0]   sum;

    // Both operands are below modv, so one subtraction always wraps.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, add_in};
        carry = (sum >= {1'b0, modv});
        acc_nxt = carry ? MOD_W'(sum - {1'b0, modv}) : sum[MOD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (en)  acc_q <= acc_nxt;
    end

    p_acc_below_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (acc_q < modv));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

endmodule

// File: rtl/sdm_divctl.sv
module sdm_divctl
    import sdm_pkg::*;
#(
    parameter int INT_W   = 7,
    parameter int MOD_W   = 11,
    parameter int DIV_W   = 8,
    parameter int INT_MIN = 21,
    parameter int INT_MAX = 123
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_tick,
    input  logic             cfg_load,
    input  logic [INT_W-1:0] cfg_int,
    input  logic [MOD_W-1:0] cfg_frac,
    input  logic [MOD_W-1:0] cfg_mod,
    input  logic [1:0]       cfg_ref,
    output logic [DIV_W-1:0] div_ratio,
    output logic [3:0]       ref_ctl
);

    localparam int NSTAGE = 3;
    localparam int SW     = DIV_W + 1;

    logic             commit, step;
    logic [INT_W-1:0] sh_int, act_int;
    logic [MOD_W-1:0] act_frac, act_mod;
    logic [1:0]       act_ref;

    sdm_cfg_ctrl #(
        .INT_W(INT_W), .MOD_W(MOD_W), .INT_MIN(INT_MIN), .INT_MAX(INT_MAX)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .div_tick(div_tick),
        .cfg_int(cfg_int), .cfg_frac(cfg_frac), .cfg_mod(cfg_mod),
        .cfg_ref(cfg_ref), .commit(commit), .step(step), .sh_int(sh_int),
        .act_int(act_int), .act_frac(act_frac), .act_mod(act_mod),
        .act_ref(act_ref)
    );

    logic [MOD_W-1:0]  add_v [NSTAGE];
    logic [MOD_W-1:0]  nxt_v [NSTAGE];
    logic [NSTAGE-1:0] cy;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign add_v[g] = act_frac;
        end else begin : g_chain
            assign add_v[g] = nxt_v[g-1];
        end
        sdm_acc_stage #(.MOD_W(MOD_W)) i_stage (
            .clk(clk), .rst_n(rst_n), .clr(commit), .en(step),
            .add_in(add_v[g]), .modv(act_mod),
            .acc_nxt(nxt_v[g]), .carry(cy[g])
        );
    end

    logic c2_d, c3_d1, c3_d2;
    logic signed [3:0]    corr;
    logic signed [SW-1:0] div_nxt;
    logic [DIV_W-1:0]     div_q;

    // Cascade correction: c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3
    always_comb begin
        corr = $signed({3'b000, cy[0]})
             + $signed({3'b000, cy[1]}) - $signed({3'b000, c2_d})
             + $signed({3'b000, cy[2]}) - $signed({2'b00, c3_d1, 1'b0})
             + $signed({3'b000, c3_d2});
        div_nxt = $signed({{(SW-INT_W){1'b0}}, act_int})
                + {{(SW-4){corr[3]}}, corr};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
            div_q <= DIV_W'(INT_MIN);
        end else if (commit) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
            div_q <= DIV_W'(sh_int);
        end else if (step) begin
            c2_d  <= cy[1];
            c3_d1 <= cy[2];
            c3_d2 <= c3_d1;
            div_q <= div_nxt[DIV_W-1:0];
        end
    end

    assign div_ratio = div_q;

    always_comb begin
        ref_ctl = '0;
        unique case (ref_code_t'(act_ref))
            REF_X2: ref_ctl[0] = 1'b1;
            REF_X1: ref_ctl[1] = 1'b1;
            REF_D2: ref_ctl[2] = 1'b1;
            REF_D4: ref_ctl[3] = 1'b1;
            default: ref_ctl = '0;
        endcase
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !div_tick |=> $stable(div_ratio));

    p_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((int'(div_ratio) - int'(act_int)) >= -3 &&
                  (int'(div_ratio) - int'(act_int)) <= 4));

    p_commit_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (int'(div_ratio) == int'(act_int)));

    p_zero_frac_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && act_frac == '0) |=> (int'(div_ratio) == int'(act_int)));

    p_ref_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ref_ctl) && ref_ctl != '0);

endmodule

// File: tb/test_sdm_divctl.sv
module test_sdm_divctl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // entry: {pad, int[6:0], frac[10:0], mod[10:0], ref[1:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 7'd60,  11'd3,    11'd7,    2'd1},
        {1'b0, 7'd21,  11'd1,    11'd2,    2'd0},
        {1'b0, 7'd123, 11'd2046, 11'd2047, 2'd3},
        {1'b0, 7'd10,  11'd9,    11'd5,    2'd2},
        {1'b0, 7'd127, 11'd0,    11'd13,   2'd3},
        {1'b0, 7'd80,  11'd5,    11'd0,    2'd1},
        {1'b0, 7'd45,  11'd250,  11'd1000, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_tick = 1'b0;
    logic        cfg_load = 1'b0;
    logic [6:0]  cfg_int = '0;
    logic [10:0] cfg_frac = '0;
    logic [10:0] cfg_mod = '0;
    logic [1:0]  cfg_ref = '0;
    logic [7:0]  div_ratio;
    logic [3:0]  ref_ctl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdm_divctl i_sdm_divctl (
        .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .cfg_load(cfg_load),
        .cfg_int(cfg_int), .cfg_frac(cfg_frac), .cfg_mod(cfg_mod),
        .cfg_ref(cfg_ref), .div_ratio(div_ratio), .ref_ctl(ref_ctl)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) div_tick = 1'b1;
        @(negedge clk) div_tick = 1'b0;
    endtask

    task automatic load(input logic [6:0] i, input logic [10:0] f,
                        input logic [10:0] m, input logic [1:0] r);
        @(negedge clk);
        cfg_int = i; cfg_frac = f; cfg_mod = m; cfg_ref = r; cfg_load = 1'b1;
        @(negedge clk) cfg_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seq_a [12];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, ticks ignored before any configuration
        chk(div_ratio == 8'd21, "R1 reset ratio", div_ratio, 21);
        chk(ref_ctl == 4'b0010, "R1 reset ref_ctl", ref_ctl, 2);
        repeat (4) tick();
        chk(div_ratio == 8'd21, "R1 idle ticks", div_ratio, 21);

        // Table walk: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            int ii, ff, mm, rr, ic, mc, fc, prev, bad_rng, bad_zero;
            longint sum, exp_sum;
            ii = int'(VEC[v][30:24]); ff = int'(VEC[v][23:13]);
            mm = int'(VEC[v][12:2]);  rr = int'(VEC[v][1:0]);
            ic = (ii < 21) ? 21 : (ii > 123) ? 123 : ii;
            mc = (mm == 0) ? 1 : mm;
            fc = (ff >= mc) ? mc - 1 : ff;
            prev = int'(div_ratio);
            load(7'(ii), 11'(ff), 11'(mm), 2'(rr));
            chk(int'(div_ratio) == prev, "R2 load without tick", div_ratio, prev);
            tick();
            chk(int'(div_ratio) == ic, "R2/R3 commit ratio", div_ratio, ic);
            chk(ref_ctl == 4'(1 << rr), "R9 ref decode", ref_ctl, 1 << rr);
            tick(); tick();
            sum = 0; bad_rng = 0; bad_zero = 0;
            for (int k = 0; k < 6 * mc; k++) begin
                tick();
                sum += longint'(div_ratio);
                if (int'(div_ratio) - ic < -3 || int'(div_ratio) - ic > 4) bad_rng++;
                if (int'(div_ratio) != ic) bad_zero++;
            end
            exp_sum = 6 * longint'(mc) * ic + 6 * longint'(fc);
            chk(sum == exp_sum, "R6 window sum", sum, exp_sum);
            chk(bad_rng == 0, "R7 correction span", bad_rng, 0);
            if (fc == 0) chk(bad_zero == 0, "R5 constant for zero fraction", bad_zero, 0);
            if (fc != ff || mc != mm) chk(sum == exp_sum, "R4 clamped sum", sum, exp_sum);
        end

        // R8: no tick, no change
        begin
            int hold;
            tick();
            hold = int'(div_ratio);
            repeat (5) @(negedge clk);
            chk(int'(div_ratio) == hold, "R8 stable without tick", div_ratio, hold);
        end

        // R10: reload restarts the sequence
        load(7'd60, 11'd3, 11'd7, 2'd1);
        tick();
        for (int k = 0; k < 12; k++) begin
            seq_a[k] = int'(div_ratio);
            tick();
        end
        repeat (5) tick();
        load(7'd40, 11'd1, 11'd3, 2'd0);
        tick();
        chk(int'(div_ratio) == 40, "R10 new integer at commit", div_ratio, 40);
        load(7'd60, 11'd3, 11'd7, 2'd1);
        begin
            int old_v;
            old_v = int'(div_ratio);
            tick();
            chk(int'(div_ratio) == seq_a[0], "R10 replay start", div_ratio, seq_a[0]);
            for (int k = 1; k < 12; k++) begin
                tick();
                chk(int'(div_ratio) == seq_a[k], "R10 replay sequence", div_ratio, seq_a[k]);
            end
            if (old_v < 0) $display("unreachable");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule